// File: doc/BRIEF.md
# Match Timer with Watchdog Reset

This block keeps a 32-bit count that moves up by one on every clock cycle in which the tick-enable input is high. Four compare channels each hold a 32-bit target value. When an advancing step brings the count onto a channel's target, and that channel's interrupt is enabled, the block latches the event in a status register and raises the channel's level interrupt. Software acknowledges an event by writing ones to the status register.

Channel 3 can also act as a watchdog. If the arm bit is set when channel 3 hits, the block issues a single-cycle system reset request and disarms itself. The arm bit is cleared at that point, so software must arm it again before another reset can be requested. This happens whether or not the channel 3 interrupt is enabled.

All state is reached through a small word-addressed register bus. Reads return data one cycle after the access. Accesses to addresses outside the map return zero and raise a one-cycle error flag.

Top module: `match_wdog_timer`

## Requirements
- R1: After reset, the count, the four target values, status, interrupt enable and watchdog arm all read as zero, and `irq` and `sys_rst_req` are low.
- R2: In each cycle with `tick_en` high and no count write, the count rises by one and wraps from 0xFFFFFFFF to 0. Without a tick, the count holds its value.
- R3: A write to the count (offset 0x10) loads the written value, and counting resumes from it. A count write takes priority over a tick in the same cycle.
- R4: A channel event happens when a tick step brings the count to a value equal to that channel's target. The event sets status bit n (offset 0x14, bit n = channel n) only if interrupt-enable bit n (offset 0x1C) is set. With the enable bit clear, no status bit is set.
- R5: A write to status clears exactly the bits that are written as 1 and are currently set. An event in the same cycle as the write wins over the clear.
- R6: The interrupt-enable register keeps bits 11:0 of the written value and reads zero in bits 31:12.
- R7: `irq[n]` equals status bit n AND enable bit n as they stood one cycle earlier.
- R8: A channel 3 event while watchdog-arm bit 0 (offset 0x18) is set makes `sys_rst_req` high for exactly one cycle and clears the arm bit. This does not depend on the channel 3 interrupt enable.
- R9: A target value below the current count is still reached after the count wraps past 2^32.
- R10: A read or write at an unmapped offset (above 0x1C, or not word aligned) sets `bus_err` for one cycle. A read there returns zero, and a write there changes no register.
- R11: Target registers sit at 0x00, 0x04, 0x08 and 0x0C. Every read presents its data on `bus_rdata` one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count step enable |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_err | output | 1 | Unmapped access flag |
| irq | output | 4 | Per-channel level interrupts |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The random traffic sets target values a few counts ahead of the live count and keeps `tick_en` high about 70% of the time. This produces enabled hits, disabled hits, and hits that coincide with status clears and count reloads, so priority faults show up. Directed cases cover the following:
- A target below a count near 2^32, which separates wraparound equality from a magnitude compare.
- A channel 3 hit with its interrupt disabled, which separates the watchdog path from the status path.
- Full-width writes to interrupt enable, which expose masking of the upper bits.
- Unmapped accesses, which show whether the error path leaks into any register.

// File: rtl/mwt_pkg.sv
// Shared constants and register selector for the match timer.
// Assumes a word-aligned map of eight 32-bit registers starting at offset 0.
package mwt_pkg;
    localparam int CNT_W  = 32;
    localparam int NCH    = 4;
    localparam int IEN_W  = 12;
    localparam int ADDR_W = 8;

    typedef enum logic [2:0] {
        SEL_TGT0 = 3'd0, SEL_TGT1 = 3'd1, SEL_TGT2 = 3'd2, SEL_TGT3 = 3'd3,
        SEL_CNT  = 3'd4, SEL_STAT = 3'd5, SEL_ARM  = 3'd6, SEL_IEN  = 3'd7
    } reg_sel_e;

    // True when an offset lands on a mapped register.
    function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:5] == '0) && (a[1:0] == 2'b00);
    endfunction
endpackage

// File: rtl/mwt_counter.sv
// Free-running up-counter with a load port.
// Assumes a load and a tick in the same cycle resolve to the load.
module mwt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_next,
    output logic         step
);
    assign step     = tick_en && !load;
    assign cnt_next = cnt_q + W'(1);

    // Count register: load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= load_val;
        else if (step)   cnt_q <= cnt_next;
    end

    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(load_val));
    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load) |=> cnt_q == W'($past(cnt_q) + W'(1)));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/mwt_channel.sv
// One compare channel: holds a target value and flags equality on a step.
// Assumes the comparison uses the value the counter is about to take.
module mwt_channel #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic [W-1:0] cnt_next,
    output logic [W-1:0] tgt_q,
    output logic         hit
);
    // Target register, written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)  tgt_q <= '0;
        else if (wr) tgt_q <= wdata;
    end

    assign hit = step && (cnt_next == tgt_q);

    assert_tgt_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> tgt_q == $past(wdata));
endmodule

// File: rtl/match_wdog_timer.sv
// Match timer top: bus decode, status, enable, watchdog arm and interrupts.
// Assumes one access per cycle and registered read data.
module match_wdog_timer
    import mwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_err,
    output logic [NCH-1:0]    irq,
    output logic              sys_rst_req
);
    logic             acc_ok;
    reg_sel_e         sel;
    logic             wr_ok;
    logic [CNT_W-1:0] cnt_q, cnt_next;
    logic             step;
    logic [CNT_W-1:0] tgt_q [NCH];
    logic [NCH-1:0]   hit;
    logic [NCH-1:0]   stat_q;
    logic [IEN_W-1:0] ien_q;
    logic             arm_q;
    logic [NCH-1:0]   clr_mask;

    assign acc_ok = addr_ok(bus_addr);
    assign sel    = reg_sel_e'(bus_addr[4:2]);
    assign wr_ok  = bus_sel && bus_we && acc_ok;

    mwt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .load(wr_ok && sel == SEL_CNT), .load_val(bus_wdata),
        .cnt_q(cnt_q), .cnt_next(cnt_next), .step(step)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        mwt_channel #(.W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr(wr_ok && bus_addr[4:2] == 3'(n)), .wdata(bus_wdata),
            .step(step), .cnt_next(cnt_next),
            .tgt_q(tgt_q[n]), .hit(hit[n])
        );
        assert_stat_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_q[n]) |-> $past(ien_q[n]));
    end

    assign clr_mask = (wr_ok && sel == SEL_STAT) ? bus_wdata[NCH-1:0] : '0;

    // Status: enabled events set, written ones clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | (hit & ien_q[NCH-1:0]);
    end

    // Interrupt enable keeps the low field of the write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     ien_q <= '0;
        else if (wr_ok && sel == SEL_IEN) ien_q <= bus_wdata[IEN_W-1:0];
    end

    // Watchdog arm: cleared by a channel 3 hit, which also pulses the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q       <= 1'b0;
            sys_rst_req <= 1'b0;
        end else begin
            sys_rst_req <= hit[3] && arm_q;
            if (hit[3] && arm_q)              arm_q <= 1'b0;
            else if (wr_ok && sel == SEL_ARM) arm_q <= bus_wdata[0];
        end
    end

    // Level interrupts, one cycle behind status and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= '0;
        else        irq <= stat_q & ien_q[NCH-1:0];
    end

    // Registered read data and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bus_sel && !acc_ok;
            if (bus_sel && !bus_we) begin
                if (!acc_ok) bus_rdata <= '0;
                else begin
                    case (sel)
                        SEL_CNT:  bus_rdata <= cnt_q;
                        SEL_STAT: bus_rdata <= CNT_W'(stat_q);
                        SEL_ARM:  bus_rdata <= CNT_W'(arm_q);
                        SEL_IEN:  bus_rdata <= CNT_W'(ien_q);
                        default:  bus_rdata <= tgt_q[bus_addr[3:2]];
                    endcase
                end
            end
        end
    end

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == $past(stat_q & ien_q[NCH-1:0]));
    assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);
    assert_arm_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> !arm_q);
    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_sel));
endmodule

// File: tb/sim_match_wdog_timer.sv
module sim_match_wdog_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq;
    logic        sys_rst_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state built from the requirements.
    logic [31:0] m_cnt;
    logic [31:0] m_tgt [4];
    logic [3:0]  m_stat;
    logic [11:0] m_ien;
    logic        m_arm;

    always #10 clk = ~clk;

    match_wdog_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq(irq),
        .sys_rst_req(sys_rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic mapped(input logic [7:0] a);
        return (a[7:5] == 3'b000) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        if (!mapped(a)) return 32'h0;
        case (a[4:2])
            3'd4: return m_cnt;
            3'd5: return {28'h0, m_stat};
            3'd6: return {31'h0, m_arm};
            3'd7: return {20'h0, m_ien};
            default: return m_tgt[a[3:2]];
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (!mapped(a)) return "R10";
        case (a[4:2])
            3'd4: return "R2";
            3'd5: return "R5";
            3'd6: return "R8";
            3'd7: return "R6";
            default: return "R11";
        endcase
    endfunction

    // One clock: drive at the falling edge, advance the model, compare after the rising edge.
    task automatic cyc(input logic sel, input logic we, input logic [7:0] a,
                       input logic [31:0] d, input logic tk);
        logic        wok, step;
        logic [3:0]  hit, clr, exp_irq;
        logic [31:0] exp_rd, nxt;
        logic        exp_rst, exp_err;
        bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
        wok  = sel && we && mapped(a);
        step = tk && !(wok && a[4:2] == 3'd4);
        nxt  = m_cnt + 32'd1;
        for (int n = 0; n < 4; n++) hit[n] = step && (nxt == m_tgt[n]);
        clr     = (wok && a[4:2] == 3'd5) ? d[3:0] : 4'h0;
        exp_irq = m_stat & m_ien[3:0];
        exp_rst = hit[3] && m_arm;
        exp_err = sel && !mapped(a);
        exp_rd  = model_read(a);
        @(posedge clk);
        #2;
        if (wok && a[4:2] == 3'd4) m_cnt = d;
        else if (step) m_cnt = nxt;
        if (wok && a[4:2] < 3'd4) m_tgt[a[3:2]] = d;
        m_stat = (m_stat & ~clr) | (hit & m_ien[3:0]);
        if (exp_rst) m_arm = 1'b0;
        else if (wok && a[4:2] == 3'd6) m_arm = d[0];
        if (wok && a[4:2] == 3'd7) m_ien = d[11:0];
        chk("R7 irq", {28'h0, irq}, {28'h0, exp_irq});
        chk("R8 sys_rst_req", {31'h0, sys_rst_req}, {31'h0, exp_rst});
        chk("R10 bus_err", {31'h0, bus_err}, {31'h0, exp_err});
        if (sel && !we) chk(tag_of(a), bus_rdata, exp_rd);
        @(negedge clk);
        bus_sel = 1'b0; tick_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, 1'b0);
    endtask

    task automatic rd(input logic [7:0] a);
        cyc(1'b1, 1'b0, a, 32'h0, 1'b0);
    endtask

    task automatic idle(input int n, input logic tk);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h0, 32'h0, tk);
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_cnt = 0; m_stat = 0; m_ien = 0; m_arm = 0;
        for (int n = 0; n < 4; n++) m_tgt[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every register reads zero after reset
        for (int r = 0; r < 8; r++) begin
            rd(8'(r * 4));
            chk("R1 reset value", bus_rdata, 32'h0);
        end
        chk("R1 outputs", {30'h0, irq == 4'h0, sys_rst_req}, {30'h0, 1'b1, 1'b0});
        // R6: enable keeps twelve bits
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C);
        chk("R6 enable width", bus_rdata, 32'h0000_0FFF);
        // R3 and R9: reload near the top and match after wrap
        wr(8'h00, 32'h0000_0001);
        wr(8'h10, 32'hFFFF_FFFE);
        idle(3, 1'b1);
        rd(8'h14);
        chk("R9 wrap match", bus_rdata & 32'h1, 32'h1);
        rd(8'h10);
        chk("R3 count after reload", bus_rdata, 32'h0000_0001);
        idle(1, 1'b0);
        chk("R7 irq raised", {31'h0, irq[0]}, 32'h1);
        // R5: clear only the set bit
        wr(8'h14, 32'hF); rd(8'h14);
        chk("R5 cleared", bus_rdata, 32'h0);
        // R4: disabled channel leaves no status
        wr(8'h1C, 32'h0); wr(8'h04, m_cnt + 32'd2);
        idle(3, 1'b1); rd(8'h14);
        chk("R4 disabled no status", bus_rdata, 32'h0);
        // R8: watchdog with channel 3 interrupt disabled
        wr(8'h18, 32'h1); wr(8'h0C, m_cnt + 32'd3);
        idle(4, 1'b1); rd(8'h18);
        chk("R8 arm cleared", bus_rdata, 32'h0);
        // R10: unmapped write leaves registers alone
        wr(8'h24, 32'hDEAD_BEEF); wr(8'h1E, 32'h1);
        rd(8'h1C);
        chk("R10 write ignored", bus_rdata, 32'h0);
        rd(8'h40);
        chk("R10 read zero", bus_rdata, 32'h0);
        // Random traffic with targets close to the live count
        for (int i = 0; i < 4000; i++) begin
            logic [7:0]  a;
            logic [31:0] d;
            logic [3:0]  pick;
            pick = 4'($urandom_range(0, 15));
            d = $urandom();
            case (pick)
                4'd0, 4'd1, 4'd2, 4'd3: begin a = {4'h0, pick[1:0], 2'b00}; d = m_cnt + 32'($urandom_range(1, 12)); end
                4'd4: begin a = 8'h10; if (d[0]) d = 32'hFFFF_FFF0 + 32'(d[3:1]); end
                4'd5: a = 8'h14;
                4'd6: begin a = 8'h18; d = 32'(d[0]); end
                4'd7: a = 8'h1C;
                4'd8: a = 8'h20 + 8'(d[2:0]);
                default: a = 8'(4 * $urandom_range(0, 7));
            endcase
            if ($urandom_range(0, 2) == 0)
                cyc(1'b0, 1'b0, 8'h0, 32'h0, $urandom_range(0, 9) < 7);
            else
                cyc(1'b1, $urandom_range(0, 1) == 1, a, d, $urandom_range(0, 9) < 7);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule